// File: doc/BRIEF.md
# Context Stack Sequencer

The sequencer saves and restores execution context through a byte-wide synchronous RAM. It handles five operations: subroutine call, subroutine return, hardware interrupt entry, software break entry and interrupt return. The stack pointer is 8 bits wide and supplies the low address byte. A page-select input sets the high byte. Each operation runs as a fixed series of single-byte RAM accesses, one per cycle. A one-cycle done strobe ends the series, and the restored program counter, status byte and pointer are valid in that cycle.

A request is a valid/ready handshake on `req_valid`/`req_ready`. `req_ready` is high only while the block is idle, so holding a request back simply keeps `req_valid` high until `req_ready` rises. A request presented while a sequence runs is not taken and is lost unless the requester holds it. The RAM port has no back-pressure. The block assumes read data one cycle after the address.

Top module: `ctx_stack_seq`

## Requirements
- R1: After reset `sp_out` equals the SP_RESET parameter, `ps_out` is 0x04 (interrupt-disable flag, bit 2, set; all other bits 0), `busy` and `done` are 0 and `req_ready` is 1.
- R2: A push writes at address {page byte, sp}, where the page byte is 0x00 when `page_sel` is 0 and 0x01 when it is 1, and then decrements sp.
- R3: A pop first increments sp and then reads at {page byte, incremented sp}.
- R4: Op code 0 (call) pushes `pc_in[15:8]` and then `pc_in[7:0]`, leaving sp lower by 2 and `pc_out`/`ps_out` unchanged.
- R5: Op code 1 (return) pops the low PC byte and then the high byte into `pc_out`, leaving sp higher by 2.
- R6: Op code 2 (hardware interrupt) is taken only when `irq_en` is 1 and `ps_in` bit 2 is 0. It pushes the PC high byte, the PC low byte, and then `ps_in` with bit 4 cleared. It then reads the vector low byte at `vec_addr` and the high byte at `vec_addr+1` into `pc_out`. It sets `ps_out` to `ps_in` with bit 2 set and bit 4 cleared.
- R7: Op code 3 (software break) runs the sequence of R6 whatever the values of `irq_en` and bit 2 of `ps_in`, but the pushed status copy has bit 4 set.
- R8: Op code 4 (interrupt return) pops the status byte, then the PC low byte, then the PC high byte. `ps_out` gets the popped status with bit 4 cleared, so the live copy never shows bit 4 set.
- R9: A hardware interrupt that is not enabled, and op codes 5 to 7, are consumed without any RAM access, change to sp or done strobe.
- R10: `busy` is high from the cycle after acceptance until the sequence ends. While it is high `req_ready` is 0 and a presented request has no effect.
- R11: sp wraps modulo 256 inside the selected page: 0x00 minus one gives 0xFF, and 0xFF plus one gives 0x00.
- R12: `done` is high for exactly one cycle per taken request. `pc_out`, `ps_out` and `sp_out` hold the results in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Block idle; request taken on valid and ready |
| req_op | input | 3 | Op code: 0 call, 1 return, 2 interrupt, 3 break, 4 interrupt return |
| pc_in | input | 16 | Program counter to save |
| ps_in | input | 8 | Current status byte |
| page_sel | input | 1 | Stack page select |
| irq_en | input | 1 | Enable bit of the requesting interrupt source |
| vec_addr | input | 16 | Address of the vector low byte |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after the address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| pc_out | output | 16 | Restored program counter or fetched vector |
| ps_out | output | 8 | Live status byte |
| sp_out | output | 8 | Stack pointer |

## Verification
The bench builds the block with SP_RESET set to 0x03. With that value, a call followed by an interrupt entry carries the pointer through 0x00 to 0xFF within the first few pushes, and the returns bring it back across the same boundary. That exercises the wrap in both directions, with nested frames on the stack. Both page-select values are used. The page-1 frames sit at 0x01xx in the bench RAM, so the high-address-byte rule is visible. The vectors sit well outside both stack pages.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  localparam logic [2:0] OPC_CALL = 3'd0;
  localparam logic [2:0] OPC_RET  = 3'd1;
  localparam logic [2:0] OPC_IRQ  = 3'd2;
  localparam logic [2:0] OPC_BRK  = 3'd3;
  localparam logic [2:0] OPC_RETI = 3'd4;

  localparam int IDX_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_END   = 4'd1,
    ST_W_PCH = 4'd2,
    ST_W_PCL = 4'd3,
    ST_W_PS  = 4'd4,
    ST_R_PCH = 4'd5,
    ST_R_PCL = 4'd6,
    ST_R_PS  = 4'd7,
    ST_R_VLO = 4'd8,
    ST_R_VHI = 4'd9
  } step_e;

  function automatic step_e step_at(input logic [2:0] op, input logic [IDX_W-1:0] idx);
    step_e s;
    s = ST_END;
    case (op)
      OPC_CALL: case (idx)
        3'd0: s = ST_W_PCH;
        3'd1: s = ST_W_PCL;
        default: s = ST_END;
      endcase
      OPC_RET: case (idx)
        3'd0: s = ST_R_PCL;
        3'd1: s = ST_R_PCH;
        default: s = ST_END;
      endcase
      OPC_IRQ, OPC_BRK: case (idx)
        3'd0: s = ST_W_PCH;
        3'd1: s = ST_W_PCL;
        3'd2: s = ST_W_PS;
        3'd3: s = ST_R_VLO;
        3'd4: s = ST_R_VHI;
        default: s = ST_END;
      endcase
      OPC_RETI: case (idx)
        3'd0: s = ST_R_PS;
        3'd1: s = ST_R_PCL;
        3'd2: s = ST_R_PCH;
        default: s = ST_END;
      endcase
      default: s = ST_END;
    endcase
    return s;
  endfunction

  function automatic logic is_push(input step_e s);
    return (s == ST_W_PCH) || (s == ST_W_PCL) || (s == ST_W_PS);
  endfunction

  function automatic logic is_pop(input step_e s);
    return (s == ST_R_PCH) || (s == ST_R_PCL) || (s == ST_R_PS);
  endfunction

  function automatic logic is_vec(input step_e s);
    return (s == ST_R_VLO) || (s == ST_R_VHI);
  endfunction

endpackage

// File: rtl/ctx_sp_unit.sv
module ctx_sp_unit #(
  parameter int SP_W = 8,
  parameter logic [SP_W-1:0] SP_RESET = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_up
);

  logic [SP_W-1:0] sp_q;

  assign sp    = sp_q;
  assign sp_up = sp_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_RESET;
    end else if (push) begin
      sp_q <= sp_q - 1'b1;
    end else if (pop) begin
      sp_q <= sp_up;
    end
  end

  // R2 / R11: a push leaves the pointer one lower, modulo the pointer width
  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp_q == SP_W'($past(sp_q) - 1'b1)));

  // R3 / R11: a pop leaves the pointer one higher, modulo the pointer width
  p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (sp_q == SP_W'($past(sp_q) + 1'b1)));

  p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop) |=> $stable(sp_q));

endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
  import ctx_stack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic       irq_ok,
  output logic       req_ready,
  output logic       start,
  output logic [2:0] op_q,
  output step_e      step,
  output logic       fin,
  output logic       busy,
  output logic       done
);

  logic             busy_q;
  logic             done_q;
  logic [IDX_W-1:0] idx_q;
  logic             legal;

  always_comb begin
    case (req_op)
      OPC_CALL, OPC_RET, OPC_BRK, OPC_RETI: legal = 1'b1;
      OPC_IRQ: legal = irq_ok;
      default: legal = 1'b0;
    endcase
  end

  assign req_ready = !busy_q;
  assign start     = req_valid && !busy_q && legal;
  assign step      = busy_q ? step_at(op_q, idx_q) : ST_IDLE;
  assign fin       = busy_q && (step == ST_END);
  assign busy      = busy_q;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      op_q   <= OPC_CALL;
    end else begin
      done_q <= fin;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        op_q   <= req_op;
      end else if (fin) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> busy_q);

  p_op_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> $stable(op_q));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_after_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

endmodule

// File: rtl/ctx_mem_drive.sv
module ctx_mem_drive
  import ctx_stack_pkg::*;
#(
  parameter int SP_W = 8,
  parameter int PC_W = 16,
  parameter int DW   = 8
) (
  input  step_e           step,
  input  logic            page,
  input  logic [SP_W-1:0] sp,
  input  logic [SP_W-1:0] sp_up,
  input  logic [PC_W-1:0] pc_save,
  input  logic [DW-1:0]   ps_save,
  input  logic [PC_W-1:0] vec,
  output logic            push,
  output logic            pop,
  output logic            mem_en,
  output logic            mem_we,
  output logic [PC_W-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata
);

  localparam int PAD_W = PC_W - SP_W - 1;

  logic [PC_W-1:0] wr_addr;
  logic [PC_W-1:0] rd_addr;

  assign push    = is_push(step);
  assign pop     = is_pop(step);
  assign wr_addr = {{PAD_W{1'b0}}, page, sp};
  assign rd_addr = {{PAD_W{1'b0}}, page, sp_up};

  always_comb begin
    mem_en    = push || pop || is_vec(step);
    mem_we    = push;
    mem_addr  = '0;
    mem_wdata = '0;
    case (step)
      ST_W_PCH: begin mem_addr = wr_addr; mem_wdata = pc_save[PC_W-1 -: DW]; end
      ST_W_PCL: begin mem_addr = wr_addr; mem_wdata = pc_save[DW-1:0]; end
      ST_W_PS:  begin mem_addr = wr_addr; mem_wdata = ps_save; end
      ST_R_PCH, ST_R_PCL, ST_R_PS: mem_addr = rd_addr;
      ST_R_VLO: mem_addr = vec;
      ST_R_VHI: mem_addr = vec + 1'b1;
      default: begin mem_addr = '0; mem_wdata = '0; end
    endcase
  end

endmodule

// File: rtl/ctx_restore.sv
module ctx_restore
  import ctx_stack_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int DW    = 8,
  parameter int I_BIT = 2,
  parameter int B_BIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  step_e           step,
  input  logic            fin,
  input  logic [2:0]      op_q,
  input  logic [DW-1:0]   ps_q,
  input  logic [DW-1:0]   mem_rdata,
  output logic [PC_W-1:0] pc_out,
  output logic [DW-1:0]   ps_out
);

  localparam logic [DW-1:0] I_MASK = DW'(1) << I_BIT;
  localparam logic [DW-1:0] B_MASK = DW'(1) << B_BIT;

  step_e           cap_q;
  logic [PC_W-1:0] pc_r;
  logic [DW-1:0]   ps_r;

  assign pc_out = pc_r;
  assign ps_out = ps_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= ST_IDLE;
      pc_r  <= '0;
      ps_r  <= I_MASK;
    end else begin
      cap_q <= step;
      case (cap_q)
        ST_R_PCL, ST_R_VLO: pc_r[DW-1:0] <= mem_rdata;
        ST_R_PCH, ST_R_VHI: pc_r[PC_W-1 -: DW] <= mem_rdata;
        ST_R_PS: ps_r <= mem_rdata & ~B_MASK;
        default: ;
      endcase
      if (fin && (op_q == OPC_IRQ || op_q == OPC_BRK)) begin
        ps_r <= (ps_q | I_MASK) & ~B_MASK;
      end
    end
  end

  p_irq_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && (op_q == OPC_IRQ || op_q == OPC_BRK)) |=> ps_r[I_BIT]);

  p_live_b_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ps_r[B_BIT]);

endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_stack_pkg::*;
#(
  parameter int SP_W = 8,
  parameter int PC_W = 16,
  parameter int DW   = 8,
  parameter int I_BIT = 2,
  parameter int B_BIT = 4,
  parameter logic [SP_W-1:0] SP_RESET = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [PC_W-1:0] pc_in,
  input  logic [DW-1:0]   ps_in,
  input  logic            page_sel,
  input  logic            irq_en,
  input  logic [PC_W-1:0] vec_addr,
  output logic            mem_en,
  output logic            mem_we,
  output logic [PC_W-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            busy,
  output logic            done,
  output logic [PC_W-1:0] pc_out,
  output logic [DW-1:0]   ps_out,
  output logic [SP_W-1:0] sp_out
);

  localparam logic [DW-1:0] B_MASK = DW'(1) << B_BIT;

  logic            start, fin, push, pop, irq_ok;
  logic [2:0]      op_q;
  step_e           step;
  logic [SP_W-1:0] sp, sp_up;
  logic [PC_W-1:0] pc_q, vec_q;
  logic [DW-1:0]   ps_q, ps_save;
  logic            page_q;

  assign irq_ok  = irq_en && !ps_in[I_BIT];
  assign ps_save = (op_q == OPC_BRK) ? (ps_q | B_MASK) : (ps_q & ~B_MASK);
  assign sp_out  = sp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      vec_q  <= '0;
      ps_q   <= '0;
      page_q <= 1'b0;
    end else if (start) begin
      pc_q   <= pc_in;
      vec_q  <= vec_addr;
      ps_q   <= ps_in;
      page_q <= page_sel;
    end
  end

  ctx_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .irq_ok(irq_ok), .req_ready(req_ready), .start(start), .op_q(op_q),
    .step(step), .fin(fin), .busy(busy), .done(done)
  );

  ctx_sp_unit #(.SP_W(SP_W), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .sp(sp), .sp_up(sp_up)
  );

  ctx_mem_drive #(.SP_W(SP_W), .PC_W(PC_W), .DW(DW)) u_drive (
    .step(step), .page(page_q), .sp(sp), .sp_up(sp_up), .pc_save(pc_q),
    .ps_save(ps_save), .vec(vec_q), .push(push), .pop(pop), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  ctx_restore #(.PC_W(PC_W), .DW(DW), .I_BIT(I_BIT), .B_BIT(B_BIT)) u_restore (
    .clk(clk), .rst_n(rst_n), .step(step), .fin(fin), .op_q(op_q),
    .ps_q(ps_q), .mem_rdata(mem_rdata), .pc_out(pc_out), .ps_out(ps_out)
  );

  // R2 / R3: every stack access lands in the page chosen at acceptance
  p_stack_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push || pop) |-> (mem_addr[PC_W-1:SP_W] == (PC_W-SP_W)'(page_q)));

  p_write_is_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_en && push));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

endmodule

// File: tb/ctx_stack_seq_bench.sv
module ctx_stack_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] SP_RST = 8'h03;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic [15:0] pc_in = '0;
  logic [7:0]  ps_in = '0;
  logic        page_sel = 1'b0;
  logic        irq_en = 1'b0;
  logic [15:0] vec_addr = '0;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [15:0] pc_out;
  logic [7:0]  ps_out, sp_out;

  logic [7:0] ram [0:1023];

  int n_chk = 0;
  int n_fail = 0;
  logic finished = 1'b0;

  logic [31:0] q_exp [$];
  string       q_tag [$];
  logic        prev_done = 1'b0;
  int          n_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_stack_seq #(.SP_RESET(SP_RST)) u_ctx_stack_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .pc_in(pc_in), .ps_in(ps_in), .page_sel(page_sel),
    .irq_en(irq_en), .vec_addr(vec_addr), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .pc_out(pc_out), .ps_out(ps_out), .sp_out(sp_out)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
      mem_rdata <= ram[mem_addr[9:0]];
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: compare each done against the scoreboard head
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R12 done longer than one cycle", 32'd1, 32'd0);
      if (done) begin
        n_done++;
        if (q_exp.size() == 0) begin
          chk(1'b0, "R9 unexpected done", 32'd1, 32'd0);
        end else begin
          logic [31:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          chk({pc_out, ps_out, sp_out} == e, t, {pc_out, ps_out, sp_out}, e);
        end
      end
      prev_done = done;
    end
  end

  task automatic expect_out(input logic [15:0] pc, input logic [7:0] ps, input logic [7:0] sp, input string tag);
    q_exp.push_back({pc, ps, sp});
    q_tag.push_back(tag);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] pc, input logic [7:0] ps,
                       input logic pg, input logic ien, input logic [15:0] vec);
    @(negedge clk);
    req_op = op; pc_in = pc; ps_in = ps; page_sel = pg; irq_en = ien; vec_addr = vec;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done;
    int base;
    base = n_done;
    for (int i = 0; i < 20; i++) begin
      if (n_done != base) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    summary();
  end

  initial begin
    for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
    ram[10'h200] = 8'h40; ram[10'h201] = 8'h80;
    ram[10'h202] = 8'h22; ram[10'h203] = 8'h11;
    ram[10'h0FF] = 8'hEE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp_out == SP_RST, "R1 reset sp", 32'(sp_out), 32'(SP_RST));
    chk(ps_out == 8'h04, "R1 reset status", 32'(ps_out), 32'h04);
    chk(!busy && !done && req_ready, "R1 reset handshake", {busy, done, req_ready}, 32'b001);

    // R4 call on page 0
    expect_out(16'h0000, 8'h04, 8'h01, "R4 call outputs");
    issue(3'd0, 16'h1234, 8'h00, 1'b0, 1'b0, 16'h0);
    chk(busy == 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
    wait_done();
    chk(ram[10'h003] == 8'h12 && ram[10'h002] == 8'h34, "R2 R4 call frame",
        {ram[10'h003], ram[10'h002]}, 32'h1234);

    // R6 hardware interrupt crosses 0x00 -> 0xFF (R11)
    expect_out(16'h8040, 8'h04, 8'hFE, "R6 irq outputs");
    issue(3'd2, 16'hABCD, 8'h10, 1'b0, 1'b1, 16'h0200);
    wait_done();
    chk(ram[10'h001] == 8'hAB && ram[10'h000] == 8'hCD, "R6 irq pc bytes",
        {ram[10'h001], ram[10'h000]}, 32'hABCD);
    chk(ram[10'h0FF] == 8'h00, "R11 R6 wrapped status push with bit4 clear", 32'(ram[10'h0FF]), 32'h00);

    // R9 interrupt masked by I flag, and disabled source
    issue(3'd2, 16'h7777, 8'h04, 1'b0, 1'b1, 16'h0200);
    repeat (8) @(negedge clk);
    chk(sp_out == 8'hFE && !busy, "R9 masked irq ignored", {busy, sp_out}, 32'h00FE);
    issue(3'd2, 16'h7777, 8'h00, 1'b0, 1'b0, 16'h0200);
    repeat (8) @(negedge clk);
    chk(sp_out == 8'hFE && ram[10'h0FE] == 8'h00, "R9 disabled irq ignored", 32'(sp_out), 32'hFE);

    // R7 software break with I set
    expect_out(16'h1122, 8'h05, 8'hFB, "R7 brk outputs");
    issue(3'd3, 16'h5566, 8'h05, 1'b0, 1'b0, 16'h0202);
    wait_done();
    chk(ram[10'h0FE] == 8'h55 && ram[10'h0FD] == 8'h66, "R7 brk pc bytes",
        {ram[10'h0FE], ram[10'h0FD]}, 32'h5566);
    chk(ram[10'h0FC] == 8'h15, "R7 brk pushed status bit4 set", 32'(ram[10'h0FC]), 32'h15);

    // R8 interrupt returns unwind both frames
    expect_out(16'h5566, 8'h05, 8'hFE, "R8 reti from brk");
    issue(3'd4, 16'h0, 8'h00, 1'b0, 1'b0, 16'h0);
    wait_done();
    expect_out(16'hABCD, 8'h00, 8'h01, "R8 R11 reti across wrap");
    issue(3'd4, 16'h0, 8'h00, 1'b0, 1'b0, 16'h0);
    wait_done();

    // R5 return from first call
    expect_out(16'h1234, 8'h00, 8'h03, "R5 ret outputs");
    issue(3'd1, 16'h0, 8'h00, 1'b0, 1'b0, 16'h0);
    wait_done();

    // R10 request during busy is ignored; page 1 call (R2)
    expect_out(16'h1234, 8'h00, 8'h01, "R10 call page1 outputs");
    issue(3'd0, 16'h9A0B, 8'h00, 1'b1, 1'b0, 16'h0);
    req_op = 3'd1; req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 ready low while busy", 32'(req_ready), 32'd0);
    req_valid = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    chk(sp_out == 8'h01, "R10 busy request had no effect", 32'(sp_out), 32'h01);
    chk(ram[10'h103] == 8'h9A && ram[10'h102] == 8'h0B, "R2 page1 high address byte",
        {ram[10'h103], ram[10'h102]}, 32'h9A0B);

    expect_out(16'h9A0B, 8'h00, 8'h03, "R3 R5 ret page1");
    issue(3'd1, 16'h0, 8'h00, 1'b1, 1'b0, 16'h0);
    wait_done();

    // R9 undefined op code
    issue(3'd6, 16'h4444, 8'h00, 1'b0, 1'b0, 16'h0);
    repeat (8) @(negedge clk);
    chk(sp_out == 8'h03 && pc_out == 16'h9A0B, "R9 undefined op ignored", {pc_out, sp_out}, 32'h9A0B03);

    chk(q_exp.size() == 0, "R12 every taken request completed", 32'(q_exp.size()), 32'd0);
    chk(n_done == 8, "R12 done count", 32'(n_done), 32'd8);
    summary();
  end

endmodule